// File: doc/BRIEF.md
# Address Decoder with Error Responder

This block sits at the centre of the address/control channel of a split-transfer bus. An initiator presents an address packet: a 32-bit address, a size code, a read/write opcode, an initiator tag, a 2-bit privilege code, a 3-bit sequentiality hint and a lock bit. The block compares the address against a set of regions, each given as a base and a mask. It forwards the packet unchanged to exactly one target select and passes that target's acceptance back to the initiator.

Some packets cannot be routed: either no region matches, or the privilege code is not allowed in the matching region. For such a packet the block acts as the target itself. It accepts the address cycle, then starts a data cycle of its own on the data/error channel with the error flag set. That data cycle carries the packet's tag and opcode, so the failed access ends as a normal split transfer addressed to the right initiator. No further address packet is taken until that error data cycle has been handed over. Responses therefore keep the order in which addresses were accepted.

Top module: `addr_err_ctrl`

## Requirements
- R1: After reset, no target select is active, `t_valid` is 0, `d_valid` is 0 and `a_ready` is 0 while `a_valid` is 0.
- R2: A packet whose address satisfies `(a_addr & MASK[i]) == BASE[i]` for region i, and whose privilege is allowed there, raises `t_valid` with `t_sel` one-hot at bit i in the same cycle. All packet fields appear unchanged on the `t_*` outputs.
- R3: When several regions match, the region with the lowest index is selected.
- R4: For a routed packet, `a_ready` equals the `t_ready` bit of the selected target in the same cycle.
- R5: A packet matching no region is accepted at once (`a_ready`=1, `t_valid`=0). From the next cycle, `d_valid`=1, `d_err`=1 and `d_rdata`=0, with `d_tag` and `d_write` equal to the packet's tag and opcode.
- R6: Privilege code bit 0 is 1 for supervisor and 0 for user. Bit 1 is 1 for data access and 0 for instruction fetch. A user access to a region with its `ALLOW_USER` bit clear, or a fetch from a region with its `ALLOW_FETCH` bit clear, is answered as in R5 and reaches no target.
- R7: While `d_valid`=1 and `d_ready`=0, `d_valid`, `d_tag`, `d_write`, `d_err` and `d_rdata` hold their values. `d_valid` falls in the cycle after `d_ready` is seen high.
- R8: While an error data cycle is pending (`d_valid`=1), `a_ready`=0 and `t_valid`=0, whatever the address. The next packet is taken only after the handover.
- R9: The size code, sequentiality hint, lock bit and privilege code are passed through unaltered to the selected target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Address packet present |
| a_ready | output | 1 | Address packet accepted this cycle |
| a_addr | input | 32 | Transfer address |
| a_size | input | 2 | Size code (byte, half-word, word) |
| a_write | input | 1 | Opcode: 1 write, 0 read |
| a_tag | input | TAG_W | Initiator tag |
| a_priv | input | 2 | Privilege code (bit1 data/fetch, bit0 supervisor/user) |
| a_seq | input | 3 | Sequentiality hint |
| a_lock | input | 1 | Atomic with the following transfer |
| t_valid | output | 1 | Packet forwarded to a target |
| t_sel | output | NT | One-hot target select |
| t_ready | input | NT | Per-target acceptance |
| t_addr | output | 32 | Forwarded address |
| t_size | output | 2 | Forwarded size |
| t_write | output | 1 | Forwarded opcode |
| t_tag | output | TAG_W | Forwarded tag |
| t_priv | output | 2 | Forwarded privilege |
| t_seq | output | 3 | Forwarded hint |
| t_lock | output | 1 | Forwarded lock |
| d_valid | output | 1 | Error data cycle active |
| d_ready | input | 1 | Data channel has taken the error cycle |
| d_tag | output | TAG_W | Tag copied from the failed packet |
| d_write | output | 1 | Opcode copied from the failed packet |
| d_err | output | 1 | Error flag |
| d_rdata | output | 32 | Read data, zero on error |

## Verification
The bench first sends addresses that fall in exactly one region, one address in each region. These show that every base/mask pair decodes. It then sends an address covered by two regions, which exposes a wrong priority order. Addresses outside every region, and legal addresses with forbidden privilege codes, separate the two error causes from a routed access. A stalled data channel, with new packets arriving during the stall, shows whether the held response stays stable and whether later packets are kept back until the handover.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int ADDR_W = 32;
  // privilege code bit positions
  localparam int PRIV_SUP_BIT  = 0;  // 1 = supervisor
  localparam int PRIV_DATA_BIT = 1;  // 1 = data access, 0 = fetch

  function automatic logic region_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [ADDR_W-1:0] mask);
    return (addr & mask) == base;
  endfunction

  function automatic logic priv_ok(input logic [1:0] priv,
                                   input logic user_allowed,
                                   input logic fetch_allowed);
    logic user_bad, fetch_bad;
    user_bad  = !priv[PRIV_SUP_BIT]  && !user_allowed;
    fetch_bad = !priv[PRIV_DATA_BIT] && !fetch_allowed;
    return !(user_bad || fetch_bad);
  endfunction
endpackage

// File: rtl/adec_region_match.sv
module adec_region_match #(
  parameter int NT = 4,
  parameter logic [NT*32-1:0] BASES = '0,
  parameter logic [NT*32-1:0] MASKS = '0
) (
  input  logic [31:0]   addr,
  output logic [NT-1:0] hits
);
  for (genvar i = 0; i < NT; i++) begin : g_reg
    assign hits[i] = adec_pkg::region_hit(addr, BASES[i*32 +: 32], MASKS[i*32 +: 32]);
  end
endmodule

// File: rtl/adec_prio_pick.sv
module adec_prio_pick #(
  parameter int NT = 4
) (
  input  logic [NT-1:0] hits,
  output logic [NT-1:0] pick,
  output logic          any
);
  logic [NT:0] lower_hit;
  assign lower_hit[0] = 1'b0;
  for (genvar i = 0; i < NT; i++) begin : g_pr
    assign pick[i]        = hits[i] && !lower_hit[i];
    assign lower_hit[i+1] = lower_hit[i] || hits[i];
  end
  assign any = lower_hit[NT];

  // R3
  lowest_wins_chk: assert final ($onehot0(pick) && (any == (pick != '0)));
endmodule

// File: rtl/adec_err_resp.sv
module adec_err_resp #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             load_write,
  input  logic             d_ready,
  output logic             d_valid,
  output logic [TAG_W-1:0] d_tag,
  output logic             d_write,
  output logic             d_err,
  output logic [31:0]      d_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_tag   <= '0;
      d_write <= 1'b0;
      d_err   <= 1'b0;
    end else if (load) begin
      d_valid <= 1'b1;
      d_tag   <= load_tag;
      d_write <= load_write;
      d_err   <= 1'b1;
    end else if (d_valid && d_ready) begin
      d_valid <= 1'b0;
      d_err   <= 1'b0;
    end
  end
  assign d_rdata = '0;

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_tag) && $stable(d_write) && d_err);
  // R7
  resp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && d_ready && !load |=> !d_valid);
endmodule

// File: rtl/addr_err_ctrl.sv
module addr_err_ctrl #(
  parameter int NT    = 4,
  parameter int TAG_W = 2,
  parameter logic [NT*32-1:0] BASES = {32'h0000_0000, 32'h8000_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [NT*32-1:0] MASKS = {32'hFFF0_0000, 32'hFFFF_F000, 32'hFFFF_0000, 32'hFFFF_0000},
  parameter logic [NT-1:0] ALLOW_USER  = 4'b1011,
  parameter logic [NT-1:0] ALLOW_FETCH = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [31:0]      a_addr,
  input  logic [1:0]       a_size,
  input  logic             a_write,
  input  logic [TAG_W-1:0] a_tag,
  input  logic [1:0]       a_priv,
  input  logic [2:0]       a_seq,
  input  logic             a_lock,
  output logic             t_valid,
  output logic [NT-1:0]    t_sel,
  input  logic [NT-1:0]    t_ready,
  output logic [31:0]      t_addr,
  output logic [1:0]       t_size,
  output logic             t_write,
  output logic [TAG_W-1:0] t_tag,
  output logic [1:0]       t_priv,
  output logic [2:0]       t_seq,
  output logic             t_lock,
  output logic             d_valid,
  input  logic             d_ready,
  output logic [TAG_W-1:0] d_tag,
  output logic             d_write,
  output logic             d_err,
  output logic [31:0]      d_rdata
);
  logic [NT-1:0] hits, pick;
  logic          any_hit, perm_ok, route_ok, busy, tgt_rdy, err_take;

  adec_region_match #(.NT(NT), .BASES(BASES), .MASKS(MASKS)) u_match (
    .addr(a_addr), .hits(hits));

  adec_prio_pick #(.NT(NT)) u_pick (.hits(hits), .pick(pick), .any(any_hit));

  assign perm_ok  = adec_pkg::priv_ok(a_priv, |(pick & ALLOW_USER), |(pick & ALLOW_FETCH));
  assign route_ok = any_hit && perm_ok;
  assign busy     = d_valid;
  assign tgt_rdy  = |(pick & t_ready);
  assign err_take = a_valid && !route_ok && !busy;

  assign t_valid = a_valid && route_ok && !busy;
  assign t_sel   = t_valid ? pick : '0;
  assign a_ready = a_valid && !busy && (route_ok ? tgt_rdy : 1'b1);

  assign t_addr  = a_addr;
  assign t_size  = a_size;
  assign t_write = a_write;
  assign t_tag   = a_tag;
  assign t_priv  = a_priv;
  assign t_seq   = a_seq;
  assign t_lock  = a_lock;

  adec_err_resp #(.TAG_W(TAG_W)) u_err (
    .clk(clk), .rst_n(rst_n), .load(err_take), .load_tag(a_tag), .load_write(a_write),
    .d_ready(d_ready), .d_valid(d_valid), .d_tag(d_tag), .d_write(d_write),
    .d_err(d_err), .d_rdata(d_rdata));

  // R5
  err_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_ready && !t_valid |=> d_valid && d_err && d_rdata == '0 && d_tag == $past(a_tag));
  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> !a_ready && !t_valid);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> $onehot(t_sel));
  // R4
  ready_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> a_ready == |(t_sel & t_ready));
endmodule

// File: tb/test_addr_err_ctrl.sv
module test_addr_err_ctrl;
  localparam int NT = 4;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic a_valid = 0, a_write = 0, a_lock = 0, d_ready = 0;
  logic [31:0] a_addr = 0;
  logic [1:0] a_size = 0, a_priv = 0;
  logic [TW-1:0] a_tag = 0;
  logic [2:0] a_seq = 0;
  logic [NT-1:0] t_ready = '1;
  logic a_ready, t_valid, t_write, t_lock, d_valid, d_write, d_err;
  logic [NT-1:0] t_sel;
  logic [31:0] t_addr, d_rdata;
  logic [1:0] t_size, t_priv;
  logic [TW-1:0] t_tag, d_tag;
  logic [2:0] t_seq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  addr_err_ctrl i_addr_err_ctrl (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr),
    .a_size(a_size), .a_write(a_write), .a_tag(a_tag), .a_priv(a_priv), .a_seq(a_seq),
    .a_lock(a_lock), .t_valid(t_valid), .t_sel(t_sel), .t_ready(t_ready), .t_addr(t_addr),
    .t_size(t_size), .t_write(t_write), .t_tag(t_tag), .t_priv(t_priv), .t_seq(t_seq),
    .t_lock(t_lock), .d_valid(d_valid), .d_ready(d_ready), .d_tag(d_tag), .d_write(d_write),
    .d_err(d_err), .d_rdata(d_rdata));

  // bench's own view of the map: ROM 64K at 0, RAM 64K at 0x10000,
  // supervisor page at 0x80000000, 1M shadow at 0 (lowest priority)
  function automatic int exp_region(input logic [31:0] a);
    if (a[31:16] == 16'h0000) return 0;
    if (a[31:16] == 16'h0001) return 1;
    if (a[31:12] == 20'h80000) return 2;
    if (a[31:20] == 12'h000) return 3;
    return -1;
  endfunction

  function automatic bit exp_allowed(input int r, input logic [1:0] p);
    bit user_ok, fetch_ok;
    user_ok  = (r != 2);
    fetch_ok = (r == 0 || r == 1);
    if (!p[0] && !user_ok) return 0;
    if (!p[1] && !fetch_ok) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ad, input logic [1:0] pr, input logic [TW-1:0] tg,
                       input logic wr);
    @(negedge clk);
    a_valid = 1; a_addr = ad; a_priv = pr; a_tag = tg; a_write = wr;
    a_size = 2'd2; a_seq = 3'd5; a_lock = 1;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    a_valid = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(t_valid == 0 && d_valid == 0 && a_ready == 0 && t_sel == 0, "R1", {t_valid, d_valid}, 0);
  endtask

  task automatic t_route(input logic [31:0] ad);
    int r;
    r = exp_region(ad);
    drive(ad, 2'b11, 2'd1, 1'b0);
    chk(t_valid && t_sel == (NT'(1) << r), (r == 0 && ad[31:20] == 0) ? "R3" : "R2", t_sel, NT'(1) << r);
    chk(t_addr == ad && t_tag == 2'd1 && t_write == 0, "R2", t_addr, ad);
    chk(t_size == 2 && t_seq == 5 && t_lock && t_priv == 2'b11, "R9", {t_size, t_seq, t_lock}, {2'd2, 3'd5, 1'b1});
    chk(a_ready == 1 && d_valid == 0, "R4", a_ready, 1);
    idle();
  endtask

  task automatic t_stall_target();
    t_ready = 4'b1101;  // target 1 not ready
    drive(32'h0001_0040, 2'b11, 2'd2, 1'b1);
    chk(t_valid && t_sel == 4'b0010 && a_ready == 0, "R4", a_ready, 0);
    t_ready = '1; #1;
    chk(a_ready == 1, "R4", a_ready, 1);
    idle();
  endtask

  task automatic t_error(input logic [31:0] ad, input logic [1:0] pr, input logic [TW-1:0] tg,
                         input string req);
    drive(ad, pr, tg, 1'b1);
    chk(a_ready == 1 && t_valid == 0 && t_sel == 0, req, {a_ready, t_valid}, 2'b10);
    @(negedge clk); a_valid = 0; #1;
    chk(d_valid && d_err && d_rdata == 0 && d_tag == tg && d_write == 1, req,
        {d_valid, d_err, d_tag}, {1'b1, 1'b1, tg});
    d_ready = 1;
    @(negedge clk); d_ready = 0; #1;
    chk(d_valid == 0, "R7", d_valid, 0);
  endtask

  task automatic t_hold_off();
    drive(32'h4000_0000, 2'b11, 2'd3, 1'b0);
    @(negedge clk);
    // legal packet arrives while error response stalls
    a_addr = 32'h0000_0100; a_tag = 2'd0; #1;
    chk(d_valid && a_ready == 0 && t_valid == 0, "R8", {a_ready, t_valid}, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(d_valid && d_tag == 2'd3 && d_write == 0 && d_err, "R7", d_tag, 3);
    chk(a_ready == 0 && t_valid == 0, "R8", a_ready, 0);
    d_ready = 1;
    @(negedge clk); d_ready = 0; #1;
    chk(d_valid == 0 && t_valid && t_sel == 4'b0001 && a_ready, "R8", t_sel, 1);
    idle();
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_route(32'h0000_1234);   // overlaps 0 and 3
    t_route(32'h0001_8000);
    t_route(32'h0008_0000);   // only 3
    chk(exp_allowed(2, 2'b11), "R6", 0, 1);
    drive(32'h8000_0010, 2'b11, 2'd0, 1'b0);
    chk(t_valid && t_sel == 4'b0100, "R2", t_sel, 4'b0100);
    idle();
    t_stall_target();
    t_error(32'h4000_0000, 2'b11, 2'd2, "R5");
    t_error(32'h8000_0010, 2'b10, 2'd1, "R6");   // user to supervisor page
    t_error(32'h0008_0000, 2'b01, 2'd3, "R6");   // fetch from shadow
    chk(!exp_allowed(2, 2'b10) && exp_region(32'h4000_0000) < 0, "R6", 0, 0);
    t_hold_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule